// File: doc/BRIEF.md
# Evicted-Address Reuse Filter

This block sits beside a cache and remembers, approximately, which block addresses were thrown out recently. Every eviction is written into a compact probabilistic bit set. When the cache later misses, it asks whether the missing address is in that set. A "present" answer is taken as a hint that the block was evicted too early, so the cache can give it a favourable insertion priority. A wrong "present" answer is harmless because the result is only a prediction.

The set is a Bloom filter with two multiply-shift hash functions. Entries are never removed one by one. Each slice counts how many insertions it has taken. Once it has taken its capacity, which matches the number of cache blocks it tracks, the slice wipes its whole bit array and its counter in one cycle. This stands in for dropping the oldest entries from a first-in first-out list of victim tags.

For shared caches the filter can be split into `THREADS` equal slices, each with its own array, counter and capacity, selected by a thread id on both ports. Each slice runs a three-state machine:
- `SL_EMPTY`: the counter is zero.
- `SL_FILL`: the slice holds between one and capacity-1 insertions.
- `SL_FULL`: the counter equals the capacity, and the slice clears at the next edge.

The transitions are:
- EMPTY→FILL on an insert.
- FILL→FILL on an insert below the limit, or with no insert.
- FILL→FULL on the insert that reaches capacity.
- FULL→EMPTY on the clearing edge when no insert arrives.
- FULL→FILL on the clearing edge when an insert arrives.
- EMPTY→FULL and FULL→FULL, only when the capacity is one.

Top module: `evict_reuse_filter`

## Requirements
- R1: After reset every slice is in `SL_EMPTY` with an all-zero array and counter, so every query returns `qry_present` = 0.
- R2: Each address gives two indices into a slice array of 2^IDX_W bits, where IDX_W = clog2(8 × slice capacity). Index h is the upper IDX_W bits of the lower ADDR_W bits of `addr × M_h`. The defaults are M0 = 0x9E3779B1 and M1 = 0x85EBCA77, ADDR_W = 32 and a slice capacity of 32, so IDX_W = 8.
- R3: An insert (`ins_valid` = 1) sets both indexed bits of slice `ins_tid` at the next clock edge and adds one to that slice's counter.
- R4: `qry_present` is 1 exactly when both indexed bits of `qry_addr` are set in slice `qry_tid`. It is combinational on the current array.
- R5: A query never changes the array: an address found present stays present on later queries until a clear.
- R6: When an insert and a query arrive in the same cycle, the query answers from the array as it was before that insert.
- R7: When a slice's counter reaches its capacity (CAPACITY/THREADS), the slice stays readable for that one cycle. Its array and counter are cleared at the following edge.
- R8: An insert that arrives during a slice's full cycle is written into the freshly cleared array, leaving the counter at 1.
- R9: Slices are independent: inserts, counts and clears on one thread id leave every other slice unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Eviction address is valid this cycle |
| ins_addr | input | ADDR_W | Address of the evicted block |
| ins_tid | input | TID_W | Thread slice the eviction belongs to |
| qry_addr | input | ADDR_W | Address of the missed block |
| qry_tid | input | TID_W | Thread slice to test |
| qry_present | output | 1 | Both hashed bits of the query are set in the slice |

## Verification
The assertions in each slice check the following every cycle:
- the counter never exceeds the slice capacity;
- every insert leaves both of its bits set one cycle later;
- below the limit, the counter rises by exactly one per insert;
- the full state always leads to a counter of zero or one;
- with no insert and no clear, the array is stable.

Some behaviours involve the hash arithmetic, the thread routing and the ordering between a query and an insert on the same edge. These can only be shown by the bench scenarios, which compare against a bit-accurate model. They are:
- which address answers present;
- that a slice is still readable in its full cycle;
- that one thread's clear leaves another thread's entries intact;
- that a same-cycle query misses its own insert.

// File: rtl/erf_pkg.sv
package erf_pkg;

    localparam int NUM_HASH = 2;

    typedef enum logic [1:0] {
        SL_EMPTY = 2'd0,
        SL_FILL  = 2'd1,
        SL_FULL  = 2'd2
    } slice_state_e;

endpackage

// File: rtl/erf_hash.sv
module erf_hash #(
    parameter int                ADDR_W = 32,
    parameter int                IDX_W  = 8,
    parameter logic [ADDR_W-1:0] MULT   = 32'h9E3779B1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);

    // Keep the product truncated to ADDR_W bits, then take its top bits.
    logic [ADDR_W-1:0] prod;

    always_comb begin
        prod = addr * MULT;
        idx  = prod[ADDR_W-1 -: IDX_W];
    end

endmodule

// File: rtl/erf_slice.sv
module erf_slice
    import erf_pkg::*;
#(
    parameter int SLICE_CAP = 32,
    parameter int IDX_W     = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ins_en,
    input  logic [NUM_HASH-1:0][IDX_W-1:0] ins_idx,
    input  logic [NUM_HASH-1:0][IDX_W-1:0] qry_idx,
    output logic                           qry_hit
);

    localparam int BITS  = 2 ** IDX_W;
    localparam int CNT_W = $clog2(SLICE_CAP + 1);
    localparam logic [CNT_W-1:0] CAP_V  = CNT_W'(SLICE_CAP);
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(SLICE_CAP - 1);

    slice_state_e     state, state_nxt;
    logic [BITS-1:0]  bits, bits_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             clear_now;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SL_EMPTY;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            SL_EMPTY: if (ins_en) state_nxt = (SLICE_CAP == 1) ? SL_FULL : SL_FILL;
            SL_FILL:  if (ins_en && cnt == LAST_V) state_nxt = SL_FULL;
            SL_FULL:  if (ins_en) state_nxt = (SLICE_CAP == 1) ? SL_FULL : SL_FILL;
                      else        state_nxt = SL_EMPTY;
            default:  state_nxt = SL_EMPTY;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        clear_now = (state == SL_FULL);
        qry_hit   = 1'b1;
        for (int h = 0; h < NUM_HASH; h++)
            qry_hit = qry_hit & bits[qry_idx[h]];
    end

    // Array and counter next values: clear first, then the new insert
    always_comb begin
        bits_nxt = clear_now ? '0 : bits;
        cnt_nxt  = clear_now ? '0 : cnt;
        if (ins_en) begin
            for (int h = 0; h < NUM_HASH; h++)
                bits_nxt[ins_idx[h]] = 1'b1;
            cnt_nxt = cnt_nxt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= '0;
            cnt  <= '0;
        end else begin
            bits <= bits_nxt;
            cnt  <= cnt_nxt;
        end
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CAP_V);

    // R3
    ins_bits_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |=> (bits[$past(ins_idx[0])] && bits[$past(ins_idx[1])]));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && state != SL_FULL) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R8
    full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SL_FULL) |=> (cnt == CNT_W'($past(ins_en))));

    // R5
    bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_en && state != SL_FULL) |=> $stable(bits));

endmodule

// File: rtl/evict_reuse_filter.sv
module evict_reuse_filter
    import erf_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                CAPACITY = 64,
    parameter int                THREADS  = 2,
    parameter logic [ADDR_W-1:0] MULT0    = 32'h9E3779B1,
    parameter logic [ADDR_W-1:0] MULT1    = 32'h85EBCA77,
    localparam int               TID_W    = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [TID_W-1:0]  ins_tid,
    input  logic [ADDR_W-1:0] qry_addr,
    input  logic [TID_W-1:0]  qry_tid,
    output logic              qry_present
);

    localparam int SLICE_CAP = CAPACITY / THREADS;
    localparam int IDX_W     = $clog2(8 * SLICE_CAP);
    localparam int TID_N     = 2 ** TID_W;

    logic [NUM_HASH-1:0][IDX_W-1:0] ins_idx;
    logic [NUM_HASH-1:0][IDX_W-1:0] qry_idx;
    logic [TID_N-1:0]               hits;

    for (genvar h = 0; h < NUM_HASH; h++) begin : g_hash
        localparam logic [ADDR_W-1:0] M = (h == 0) ? MULT0 : MULT1;
        erf_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .MULT(M)) u_hins (
            .addr (ins_addr),
            .idx  (ins_idx[h])
        );
        erf_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .MULT(M)) u_hqry (
            .addr (qry_addr),
            .idx  (qry_idx[h])
        );
    end

    for (genvar t = 0; t < TID_N; t++) begin : g_slice
        if (t < THREADS) begin : g_live
            logic en;
            assign en = ins_valid && (ins_tid == TID_W'(t));
            erf_slice #(.SLICE_CAP(SLICE_CAP), .IDX_W(IDX_W)) u_slice (
                .clk     (clk),
                .rst_n   (rst_n),
                .ins_en  (en),
                .ins_idx (ins_idx),
                .qry_idx (qry_idx),
                .qry_hit (hits[t])
            );
        end else begin : g_pad
            assign hits[t] = 1'b0;
        end
    end

    assign qry_present = hits[qry_tid];

endmodule

// File: tb/evict_reuse_filter_tb.sv
module evict_reuse_filter_tb;

    localparam int          ADDR_W = 32;
    localparam int          CAP    = 64;
    localparam int          THR    = 2;
    localparam int          SCAP   = CAP / THR;
    localparam int          IDX_W  = $clog2(8 * SCAP);
    localparam int          SBITS  = 2 ** IDX_W;
    localparam logic [31:0] M0     = 32'h9E3779B1;
    localparam logic [31:0] M1     = 32'h85EBCA77;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [31:0] ins_addr = '0;
    logic        ins_tid = 1'b0;
    logic [31:0] qry_addr = '0;
    logic        qry_tid = 1'b0;
    logic        qry_present;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [SBITS-1:0] mbits [THR];
    int               mcnt  [THR];

    always #2 clk = ~clk;

    evict_reuse_filter #(.ADDR_W(ADDR_W), .CAPACITY(CAP), .THREADS(THR),
                         .MULT0(M0), .MULT1(M1)) u_dut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_addr(ins_addr),
        .ins_tid(ins_tid), .qry_addr(qry_addr), .qry_tid(qry_tid),
        .qry_present(qry_present)
    );

    // R2: multiply-shift index
    function automatic int hidx(input logic [31:0] a, input logic [31:0] m);
        logic [31:0] p;
        p = a * m;
        return int'(p[31 -: IDX_W]);
    endfunction

    function automatic logic model_q(input logic [31:0] a, input int t);
        return mbits[t][hidx(a, M0)] && mbits[t][hidx(a, M1)];
    endfunction

    function automatic logic [31:0] pool(input int i);
        return 32'h1000_0000 + 32'(i) * 32'h40;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: qry_present=%0b expected=%0b", req, act, exp);
        end
    endtask

    // One cycle: drive, check the query before the edge, then advance the model.
    task automatic cyc(input string req, input logic iv, input logic [31:0] ia,
                       input logic it, input logic [31:0] qa, input logic qt);
        @(negedge clk);
        ins_valid = iv; ins_addr = ia; ins_tid = it;
        qry_addr = qa; qry_tid = qt;
        #1;
        chk(req, qry_present, model_q(qa, int'(qt)));
        @(posedge clk);
        for (int t = 0; t < THR; t++) begin
            if (mcnt[t] == SCAP) begin
                mbits[t] = '0;
                mcnt[t]  = 0;
            end
        end
        if (iv) begin
            mbits[it][hidx(ia, M0)] = 1'b1;
            mbits[it][hidx(ia, M1)] = 1'b1;
            mcnt[it]++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int t = 0; t < THR; t++) begin mbits[t] = '0; mcnt[t] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: nothing present after reset
        for (int i = 0; i < 4; i++) cyc("R1", 0, 0, 0, pool(i), i[0]);

        // R3/R4: insert then find
        cyc("R3", 1, pool(5), 0, pool(7), 0);
        cyc("R4", 0, 0, 0, pool(5), 0);
        chk("R4 literal", qry_present, 1'b1);
        // R6: same-cycle insert and query sees old state
        cyc("R6", 1, pool(9), 0, pool(9), 0);
        chk("R6 literal", qry_present, 1'b0);
        // R5: repeated queries keep it present
        for (int i = 0; i < 3; i++) begin
            cyc("R5", 0, 0, 0, pool(9), 0);
            chk("R5 literal", qry_present, 1'b1);
        end
        // R9: thread 1 entry, thread 0 slice untouched by it
        cyc("R9", 1, pool(20), 1, pool(20), 0);
        cyc("R9", 0, 0, 0, pool(20), 1);
        chk("R9 literal", qry_present, 1'b1);

        // R7: fill thread 0 to capacity (two already in)
        for (int i = 0; i < SCAP - 2; i++) cyc("R7", 1, pool(100 + i), 0, pool(5), 0);
        cyc("R7 full cycle", 0, 0, 0, pool(5), 0);
        chk("R7 still readable", qry_present, 1'b1);
        cyc("R7 cleared", 0, 0, 0, pool(5), 0);
        chk("R7 cleared literal", qry_present, 1'b0);
        cyc("R9 other slice kept", 0, 0, 0, pool(20), 1);
        chk("R9 kept literal", qry_present, 1'b1);

        // R8: insert landing during full cycle
        for (int i = 0; i < SCAP; i++) cyc("R8", 1, pool(200 + i), 0, pool(200), 0);
        cyc("R8", 1, pool(300), 0, pool(200), 0);
        chk("R8 full cycle", qry_present, 1'b1);
        cyc("R8", 0, 0, 0, pool(300), 0);
        chk("R8 new entry", qry_present, 1'b1);
        cyc("R8", 0, 0, 0, pool(200), 0);
        chk("R8 old gone", qry_present, 1'b0);

        // Random mix against the model (R2 R3 R4 R6 R7 R9)
        for (int n = 0; n < 3000; n++) begin
            cyc("R2 random", logic'($urandom_range(0, 1)), pool($urandom_range(0, 47)),
                logic'($urandom_range(0, 1)), pool($urandom_range(0, 47)),
                logic'($urandom_range(0, 1)));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule